// File: doc/BRIEF.md
# Comma Word Aligner with Slip Reporting

This block sits behind a 20-bit deserializer. After the clock recovery loop locks, the word boundary lands on an arbitrary bit. The block finds that boundary by looking for the 10-bit comma symbol. It keeps the previous input word next to the current one, so it has a 40-bit window. It tests all twenty candidate bit offsets of that window in one cycle. Once the same offset has carried a comma twice in a row, the block freezes that offset and emits realigned 20-bit words.

The chosen offset appears on a port as a measurement result. It runs from 0 to 19. Each step is one bit time, which is 320 ps on a 3.125 Gb/s lane with 6.4 ns words. The system adds this value to a coarse word-count delay to form a fine propagation-delay figure. A resync pulse discards the lock and starts a new search.

Data flows in and out on valid/ready handshakes. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. The output holds `out_data` steady and keeps `out_valid` high until `out_ready` is seen high. While the output register is full and not being drained, `in_ready` is low, so back-pressure passes straight upstream. The `locked` and `slip` pins are plain status levels.

Top module: `comma_word_aligner`

## Requirements
- R1: After reset, `locked` and `out_valid` are 0, `slip` is 0, and `in_ready` is 1 when `out_ready` is 1.
- R2: The comma is 0011111010 or 1100000101, with the earliest-sent bit as the MSB. A comma is recognised at window offset k (0..19) when it occupies bits [39-k:30-k] of {previous word, current word}. `slip` reports that offset and never exceeds 19.
- R3: When several offsets hold a comma in the same window, the lowest offset is taken.
- R4: `locked` rises only after two consecutive comma sightings at the same offset. A sighting at a different offset replaces the candidate, and the two-sighting count starts over. Words without a comma leave the candidate unchanged.
- R5: The first word accepted after reset or resync only fills the window. A word accepted while locked, or the word that completes the lock, is emitted one cycle later. The emitted value is bits [39-slip:20-slip] of {previous word, current word}, with `out_valid` high. At lock, the comma sits in the upper ten bits. No word is emitted while unlocked.
- R6: While locked, `slip` does not change, even if commas appear at other offsets.
- R7: A resync pulse clears `locked`, `out_valid` and `slip` on the next edge and restarts the search.
- R8: When `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is 0. Otherwise `in_ready` equals not-`resync`.
- R9: `in_ready` is 0 in every cycle where `resync` is high, so no word is taken during a resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| resync | input | 1 | Drop lock and restart the comma search |
| in_data | input | 20 | Raw deserializer word, earliest bit in the MSB |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word can be taken |
| out_data | output | 20 | Realigned word |
| out_valid | output | 1 | Realigned word present |
| out_ready | input | 1 | Downstream takes the realigned word |
| locked | output | 1 | Alignment offset frozen |
| slip | output | 5 | Chosen bit offset, one unit interval per step |

## Verification
`in_ready` is combinational, so it is compared in the same cycle as the drive, a moment after the inputs settle. The effect of an accepted word on `slip` and `locked` is due at the very next rising edge. The realigned word and its `out_valid` are also due at that edge. The bench keeps a cycle model that is advanced once per drive, as though the coming edge had already happened. It compares every output against that model on the following falling edge, which is exactly one register stage after acceptance. Directed checks are made only after one extra idle cycle, so that the last accepted word has landed.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  localparam int unsigned SYM_W = 10;

  // Comma symbol in both running-disparity forms, earliest bit in the MSB.
  localparam logic [SYM_W-1:0] COMMA_A = 10'b0011111010;
  localparam logic [SYM_W-1:0] COMMA_B = 10'b1100000101;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_HUNT = 2'd1,
    ST_CONF = 2'd2,
    ST_LOCK = 2'd3
  } align_state_e;

endpackage

// File: rtl/aln_window.sv
module aln_window #(
  parameter int unsigned W = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic [W-1:0]   cur_i,
  output logic [2*W-1:0] win_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (shift_en) begin
      prev_q <= cur_i;
    end
  end

  // The older word is sent first, so it takes the upper half.
  assign win_o = {prev_q, cur_i};

endmodule

// File: rtl/aln_comma_scan.sv
module aln_comma_scan #(
  parameter int unsigned W    = 20,
  parameter int unsigned CW   = 10,
  parameter logic [CW-1:0] PAT_A = '0,
  parameter logic [CW-1:0] PAT_B = '1,
  localparam int unsigned OFFW = $clog2(W)
) (
  input  logic [2*W-1:0]  win_i,
  output logic            hit_o,
  output logic [OFFW-1:0] hit_off_o
);

  logic [W-1:0] hits;

  for (genvar k = 0; k < W; k++) begin : g_off
    logic [CW-1:0] seg;
    assign seg     = win_i[2*W-1-k -: CW];
    assign hits[k] = (seg == PAT_A) || (seg == PAT_B);
  end

  // Lowest offset takes priority.
  always_comb begin
    hit_off_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hits[k]) hit_off_o = OFFW'(k);
    end
  end

  assign hit_o = |hits;

endmodule

// File: rtl/aln_lock_ctrl.sv
module aln_lock_ctrl
  import aligner_pkg::*;
#(
  parameter int unsigned OFFW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resync,
  input  logic            acc,
  input  logic            hit,
  input  logic [OFFW-1:0] hit_off,
  output logic            locked_o,
  output logic [OFFW-1:0] off_o,
  output logic            emit_o
);

  align_state_e    st_q;
  logic [OFFW-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FILL;
      off_q <= '0;
    end else if (resync) begin
      st_q  <= ST_FILL;
      off_q <= '0;
    end else if (acc) begin
      unique case (st_q)
        ST_FILL: st_q <= ST_HUNT;
        ST_HUNT: begin
          if (hit) begin
            off_q <= hit_off;
            st_q  <= ST_CONF;
          end
        end
        ST_CONF: begin
          if (hit) begin
            if (hit_off == off_q) st_q  <= ST_LOCK;
            else                  off_q <= hit_off;
          end
        end
        ST_LOCK: st_q <= ST_LOCK;
        default: st_q <= ST_FILL;
      endcase
    end
  end

  assign emit_o   = acc && !resync &&
                    ((st_q == ST_LOCK) ||
                     ((st_q == ST_CONF) && hit && (hit_off == off_q)));
  assign locked_o = (st_q == ST_LOCK);
  assign off_o    = off_q;

endmodule

// File: rtl/aln_out_stage.sv
module aln_out_stage #(
  parameter int unsigned W = 20,
  localparam int unsigned OFFW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            load,
  input  logic [2*W-1:0]  win_i,
  input  logic [OFFW-1:0] sel,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [W-1:0]    out_data
);

  logic [2*W-1:0] shifted;
  logic [W-1:0]   aligned;

  assign shifted = win_i << sel;
  assign aligned = shifted[2*W-1 -: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= aligned;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import aligner_pkg::*;
#(
  parameter int unsigned W  = 20,
  parameter int unsigned CW = SYM_W,
  parameter logic [CW-1:0] PAT_A = COMMA_A,
  parameter logic [CW-1:0] PAT_B = COMMA_B,
  localparam int unsigned OFFW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resync,
  input  logic [W-1:0]    in_data,
  input  logic            in_valid,
  output logic            in_ready,
  output logic [W-1:0]    out_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            locked,
  output logic [OFFW-1:0] slip
);

  logic [2*W-1:0]  win;
  logic            acc;
  logic            hit;
  logic [OFFW-1:0] hit_off;
  logic            emit;

  assign in_ready = !resync && (!out_valid || out_ready);
  assign acc      = in_valid && in_ready;

  aln_window #(.W(W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(acc),
    .cur_i   (in_data),
    .win_o   (win)
  );

  aln_comma_scan #(.W(W), .CW(CW), .PAT_A(PAT_A), .PAT_B(PAT_B)) u_scan (
    .win_i    (win),
    .hit_o    (hit),
    .hit_off_o(hit_off)
  );

  aln_lock_ctrl #(.OFFW(OFFW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .resync  (resync),
    .acc     (acc),
    .hit     (hit),
    .hit_off (hit_off),
    .locked_o(locked),
    .off_o   (slip),
    .emit_o  (emit)
  );

  aln_out_stage #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (resync),
    .load     (emit),
    .win_i    (win),
    .sel      (slip),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data)
  );

endmodule

// File: rtl/comma_word_aligner_checker.sv
module comma_word_aligner_checker #(
  parameter int unsigned W  = 20,
  parameter int unsigned CW = 10,
  parameter logic [CW-1:0] PAT_A = '0,
  parameter logic [CW-1:0] PAT_B = '1,
  localparam int unsigned OFFW = $clog2(W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            resync,
  input logic            in_ready,
  input logic [W-1:0]    out_data,
  input logic            out_valid,
  input logic            out_ready,
  input logic            locked,
  input logic [OFFW-1:0] slip
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_slip_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slip) < W);

  assert_lock_upper_comma_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(locked)) |->
      (out_valid && ((out_data[W-1 -: CW] == PAT_A) || (out_data[W-1 -: CW] == PAT_B))));

  assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> locked);

  assert_slip_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(locked) && locked) |-> $stable(slip));

  assert_resync_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!locked && !out_valid && slip == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !resync) |=> (out_valid && $stable(out_data)));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_resync_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> !in_ready);

endmodule

bind comma_word_aligner comma_word_aligner_checker #(
  .W(W), .CW(CW), .PAT_A(PAT_A), .PAT_B(PAT_B)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .resync   (resync),
  .in_ready (in_ready),
  .out_data (out_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .locked   (locked),
  .slip     (slip)
);

// File: tb/comma_word_aligner_test.sv
module comma_word_aligner_test;

  localparam logic [9:0]  KP  = 10'b0011111010;
  localparam logic [9:0]  KN  = 10'b1100000101;
  localparam logic [19:0] PR_A = {10'b0011111010, 10'b1001000101};
  localparam logic [19:0] PR_B = {10'b1100000101, 10'b0110110101};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resync = 1'b0;
  logic [19:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        locked;
  logic [4:0]  slip;

  int checks = 0;
  int errors = 0;
  bit ready_rand = 1'b0;
  bit gap_rand = 1'b0;

  // Bench model of the block
  logic [19:0] m_prev = '0;
  int          m_st = 0;     // 0 fill, 1 hunt, 2 confirm, 3 locked
  int          m_slip = 0;
  bit          m_ov = 1'b0;
  logic [19:0] m_od = '0;

  always #2 clk = ~clk;

  comma_word_aligner uut (
    .clk(clk), .rst_n(rst_n), .resync(resync),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .locked(locked), .slip(slip)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest_hit(input logic [39:0] w);
    for (int k = 0; k < 20; k++) begin
      logic [9:0] s;
      s = w[39-k -: 10];
      if (s == KP || s == KN) return k;
    end
    return -1;
  endfunction

  function automatic logic [19:0] idle_word(input logic [19:0] pr, input int d);
    logic [39:0] t;
    t = {pr, pr} << d;
    return t[39:20];
  endfunction

  task automatic step(input bit r, input bit v, input logic [19:0] d, output bit a);
    bit exp_rdy;
    @(negedge clk);
    chk("R5 out_valid", 32'(out_valid), 32'(m_ov));
    if (m_ov) chk("R5 out_data", 32'(out_data), 32'(m_od));
    chk("R4 locked", 32'(locked), 32'(m_st == 3));
    chk("R2 slip", 32'(slip), 32'(m_slip));
    resync = r; in_valid = v; in_data = d;
    out_ready = ready_rand ? ($urandom % 3 != 0) : 1'b1;
    #1;
    exp_rdy = !r && (!m_ov || out_ready);
    chk(r ? "R9 in_ready" : "R8 in_ready", 32'(in_ready), 32'(exp_rdy));
    a = v && exp_rdy;
    if (r) begin
      m_st = 0; m_slip = 0; m_ov = 1'b0;
    end else begin
      bit emit = 1'b0;
      logic [39:0] w = {m_prev, d};
      if (a) begin
        int h = lowest_hit(w);
        case (m_st)
          0: m_st = 1;
          1: if (h >= 0) begin m_slip = h; m_st = 2; end
          2: if (h >= 0) begin
               if (h == m_slip) begin m_st = 3; emit = 1'b1; end
               else m_slip = h;
             end
          default: emit = 1'b1;
        endcase
        m_prev = d;
      end
      if (emit) begin
        logic [39:0] t = w << m_slip;
        m_ov = 1'b1; m_od = t[39:20];
      end else if (out_ready) begin
        m_ov = 1'b0;
      end
    end
  endtask

  task automatic send(input logic [19:0] d);
    bit a;
    if (gap_rand && ($urandom % 4 == 0)) step(1'b0, 1'b0, 20'h0, a);
    a = 1'b0;
    while (!a) step(1'b0, 1'b1, d, a);
  endtask

  task automatic idle_cycle();
    bit a;
    step(1'b0, 1'b0, 20'h0, a);
  endtask

  task automatic do_resync();
    bit a;
    step(1'b1, 1'b0, 20'h0, a);
  endtask

  initial begin
    void'($urandom(32'd20091015));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 locked after reset", 32'(locked), 32'd0);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 slip after reset", 32'(slip), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);

    // Lock at several phases and both disparity forms
    foreach (int_list[i]) begin end
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 7; i++) begin
        int dl[7] = '{0, 1, 5, 10, 13, 18, 19};
        int d = dl[i];
        logic [19:0] pr = (p == 0) ? PR_A : PR_B;
        ready_rand = 1'b0; gap_rand = (i % 2 == 1);
        do_resync();
        idle_cycle();
        chk("R7 locked cleared", 32'(locked), 32'd0);
        chk("R7 slip cleared", 32'(slip), 32'd0);
        chk("R7 out_valid cleared", 32'(out_valid), 32'd0);
        for (int n = 0; n < 4; n++) send(idle_word(pr, d));
        idle_cycle();
        chk("R4 locked after idle", 32'(locked), 32'd1);
        chk("R2 slip equals phase", 32'(slip), 32'((20 - d) % 20));
        send(idle_word(pr, d));
        idle_cycle();
        chk("R5 aligned word", 32'(out_data), 32'(pr));
        // shift incoming phase by one bit while locked
        for (int n = 0; n < 3; n++) send(idle_word(pr, (d + 1) % 20));
        idle_cycle();
        chk("R6 slip frozen", 32'(slip), 32'((20 - d) % 20));
        chk("R6 still locked", 32'(locked), 32'd1);
      end
    end

    // Lowest offset wins, candidate replacement, two sightings needed
    ready_rand = 1'b0; gap_rand = 1'b0;
    do_resync();
    send(20'h0);
    send({KP, KN});
    send(20'h0);
    idle_cycle();
    chk("R3 lowest offset", 32'(slip), 32'd0);
    chk("R4 one sighting not locked", 32'(locked), 32'd0);
    send(20'h0);
    send(20'(KP) << 4);
    send(20'h0);
    idle_cycle();
    chk("R4 candidate replaced", 32'(slip), 32'd6);
    chk("R4 not locked after replace", 32'(locked), 32'd0);
    send(20'(KP) << 4);
    send(20'h0);
    idle_cycle();
    chk("R4 locked after second", 32'(locked), 32'd1);
    chk("R4 slip after second", 32'(slip), 32'd6);

    // Fill rule: a stale previous word is not searched after resync
    do_resync();
    send(20'h0);
    send({KP, 10'h0});
    do_resync();
    send(20'h0);
    idle_cycle();
    chk("R5 fill word not searched", 32'(slip), 32'd0);
    send({KP, 10'h0});
    send({KP, 10'h0});
    idle_cycle();
    chk("R5 no early lock", 32'(locked), 32'd0);

    // Random traffic with back-pressure
    ready_rand = 1'b1; gap_rand = 1'b1;
    begin
      int d = 7;
      logic [19:0] pr = PR_A;
      for (int n = 0; n < 3000; n++) begin
        int r = $urandom % 100;
        if (r < 2) do_resync();
        else if (r < 4) d = $urandom % 20;
        else if (r < 5) pr = (pr == PR_A) ? PR_B : PR_A;
        else if (r < 20) send(20'($urandom));
        else send(idle_word(pr, d));
      end
    end
    ready_rand = 1'b0;
    repeat (3) idle_cycle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int int_list[1];

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule